// File: doc/BRIEF.md
# Dual Event-Selectable Performance Counter

A performance monitoring block that holds a small array of wide event counters (two by default, 48 bits each). The surrounding core supplies a 64-bit vector of single-cycle event indications. Bit k of that vector is the event with code k. Examples are operand reads, branches, executed instructions, interrupts and elapsed cycles. Each counter has its own 16-bit control register. The control register picks a 6-bit event code, holds a clock-select bit, and carries separate enable and start bits. A write of its clear bit zeroes the count.

Software reaches the block through a plain register port. A space select chooses between the control window and the counter window. In the counter window each counter appears as a high word and a low word. The high word carries the count bits above the low part, zero-extended to 32 bits. Reading the high word captures the low part in a shadow register, so a following low read returns a value coherent with the high word. Counts cannot be preset. There is no overflow indication, and a counter simply rolls over to zero.

Top module: `pmu_dual_counter`

## Requirements
- R1: Each counter has its own control register at control-window offset 4*i. The counters run independently, each counting only the event whose code sits in bits [5:0] of its own control register. Event input bit k carries event code k.
- R2: A counter advances by exactly one on every clock edge at which its enable bit (15) and start bit (14) are both set and its selected event input is high. With either bit clear the counter holds. A control write takes effect on counting from the following cycle.
- R3: Codes 0x00, 0x0C, 0x1B to 0x20, 0x26 and 0x2A to 0x3F are unassigned. A counter selecting one of them never advances, whatever the event inputs do.
- R4: A control write with bit 13 set zeroes that counter at the same edge and outranks a coincident increment. Bit 13 always reads back as 0.
- R5: A control register reads back bits 15, 14, 8 and 5:0 as last written. All other bits read 0.
- R6: The high word at counter-window offset 8*i returns count bits [CNT_W-1:LO_W], zero-extended. The low word at offset 8*i+4 returns count bits [LO_W-1:0], zero-extended.
- R7: A high-word read captures the current low part. The next low-word read of that counter returns the captured value and consumes it. A low read with nothing captured returns the live value. A clear discards a pending capture.
- R8: Writes to the counter window change no state.
- R9: A counter at all ones that takes an increment becomes zero, with no other indication.
- R10: After reset every control register and count is zero. Read data is zero when no read is requested or the address decodes to no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_i | input | 64 | Event indications, bit k is event code k |
| bus_space_i | input | 1 | 0 selects control window, 1 selects counter window |
| bus_addr_i | input | AW | Byte offset within the selected window |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 16 | Write data (control registers) |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |

## Verification
The bench builds the block with CNT_W=12 and LO_W=8, keeping two counters and the shadow variant. This puts the high word at bits [11:8], so a counter reaches all ones after 4095 elapsed-cycle events. The rollover of R9 and the high/low split of R6 can then be driven through the event inputs alone, since no preset exists. Alternating high and low reads while the count moves every cycle show the shadow capture of R7 returning a value one step older than the live count.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
   localparam int SEL_W    = 6;
   localparam int NEV      = 2 ** SEL_W;
   localparam int CR_W     = 16;
   localparam int B_CLKSEL = 8;
   localparam int B_CLR    = 13;
   localparam int B_START  = 14;
   localparam int B_EN     = 15;

   typedef struct packed {
      logic             en;
      logic             start;
      logic             clksel;
      logic [SEL_W-1:0] code;
   } pmu_ctrl_t;

   // sparse assignment of event codes (R3)
   function automatic logic code_assigned(input logic [SEL_W-1:0] c);
      return (c >= 6'h01 && c <= 6'h0B) || (c >= 6'h0D && c <= 6'h1A) ||
             (c >= 6'h21 && c <= 6'h25) || (c >= 6'h27 && c <= 6'h29);
   endfunction

   function automatic logic [CR_W-1:0] ctrl_image(input pmu_ctrl_t c);
      logic [CR_W-1:0] v;
      v              = '0;
      v[B_EN]        = c.en;
      v[B_START]     = c.start;
      v[B_CLKSEL]    = c.clksel;
      v[SEL_W-1:0]   = c.code;
      return v;
   endfunction
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
   import pmu_pkg::*;
(
   input  logic [NEV-1:0]   ev_i,
   input  logic [SEL_W-1:0] code_i,
   output logic             hit_o
);
   logic [NEV-1:0] live_mask;

   // one mask bit per code, fixed at elaboration
   for (genvar k = 0; k < NEV; k++) begin : g_mask
      assign live_mask[k] = code_assigned(SEL_W'(k));
   end

   assign hit_o = ev_i[code_i] & live_mask[code_i];

   always_comb begin
      if (hit_o) assert_unassigned_quiet_R3 : assert (code_assigned(code_i));
   end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
   import pmu_pkg::*;
#(
   parameter int CNT_W  = 48,
   parameter int LO_W   = 32,
   parameter bit SHADOW = 1'b1
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NEV-1:0]  ev_i,
   input  logic            ctrl_we_i,
   input  logic [CR_W-1:0] ctrl_wdata_i,
   input  logic            hi_rd_i,
   input  logic            lo_rd_i,
   output logic [CR_W-1:0] ctrl_rdata_o,
   output logic [31:0]     hi_rdata_o,
   output logic [31:0]     lo_rdata_o
);
   typedef logic [CNT_W-1:0] cnt_t;
   typedef logic [LO_W-1:0]  lo_t;

   pmu_ctrl_t ctrl_q;
   cnt_t      cnt_q;
   logic      ev_hit, run, clr_w;
   logic      unused_wbits;

   assign unused_wbits = ^{ctrl_wdata_i[12:9], ctrl_wdata_i[7:6]};
   assign run   = ctrl_q.en & ctrl_q.start;
   assign clr_w = ctrl_we_i & ctrl_wdata_i[B_CLR];

   pmu_event_sel u_sel (
      .ev_i   (ev_i),
      .code_i (ctrl_q.code),
      .hit_o  (ev_hit)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else if (ctrl_we_i) begin
         ctrl_q.en     <= ctrl_wdata_i[B_EN];
         ctrl_q.start  <= ctrl_wdata_i[B_START];
         ctrl_q.clksel <= ctrl_wdata_i[B_CLKSEL];
         ctrl_q.code   <= ctrl_wdata_i[SEL_W-1:0];
      end
   end

   // R4: clear outranks increment; R9: natural rollover
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (clr_w)         cnt_q <= '0;
      else if (run && ev_hit) cnt_q <= cnt_q + 1'b1;
   end

   assign ctrl_rdata_o = ctrl_image(ctrl_q);
   assign hi_rdata_o   = 32'(cnt_q >> LO_W);

   if (SHADOW) begin : g_shadow
      lo_t  shadow_q;
      logic pend_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            shadow_q <= '0;
            pend_q   <= 1'b0;
         end else if (clr_w) begin
            pend_q   <= 1'b0;
         end else if (hi_rd_i) begin
            shadow_q <= cnt_q[LO_W-1:0];
            pend_q   <= 1'b1;
         end else if (lo_rd_i) begin
            pend_q   <= 1'b0;
         end
      end

      assign lo_rdata_o = 32'(pend_q ? shadow_q : cnt_q[LO_W-1:0]);

      assert_shadow_load_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (hi_rd_i && !clr_w) |=> (shadow_q == $past(cnt_q[LO_W-1:0])) && pend_q);
   end else begin : g_live
      assign lo_rdata_o = 32'(cnt_q[LO_W-1:0]);
   end

   assert_clear_zero_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_w |=> (cnt_q == '0));
   assert_hold_idle_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run && !clr_w) |=> $stable(cnt_q));
   assert_step_one_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_w |=> (cnt_q == $past(cnt_q)) || (cnt_q == cnt_t'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
   import pmu_pkg::*;
#(
   parameter int CNT_W   = 48,
   parameter int LO_W    = 32,
   parameter int NUM_CTR = 2,
   parameter int AW      = 8,
   parameter bit SHADOW  = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NEV-1:0] ev_i,
   input  logic           bus_space_i,
   input  logic [AW-1:0]  bus_addr_i,
   input  logic           bus_wr_i,
   input  logic           bus_rd_i,
   input  logic [15:0]    bus_wdata_i,
   output logic [31:0]    bus_rdata_o
);
   localparam int HI_W = CNT_W - LO_W;

   if (LO_W < 1 || LO_W > 32)        begin : g_bad_lo  $error("LO_W out of range"); end
   if (HI_W < 1 || HI_W > 16)        begin : g_bad_hi  $error("CNT_W - LO_W must be 1..16"); end
   if (NUM_CTR < 1 || NUM_CTR > 8)   begin : g_bad_n   $error("NUM_CTR must be 1..8"); end
   if (8 * NUM_CTR > 2 ** AW)        begin : g_bad_aw  $error("AW too narrow for map"); end

   logic [31:0] part [NUM_CTR];

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic            sel_c, sel_h, sel_l;
      logic [CR_W-1:0] c_rd;
      logic [31:0]     h_rd, l_rd;

      assign sel_c = !bus_space_i && (bus_addr_i == AW'(4 * i));
      assign sel_h =  bus_space_i && (bus_addr_i == AW'(8 * i));
      assign sel_l =  bus_space_i && (bus_addr_i == AW'(8 * i + 4));

      pmu_counter #(.CNT_W(CNT_W), .LO_W(LO_W), .SHADOW(SHADOW)) u_cnt (
         .clk_i        (clk_i),
         .rst_ni       (rst_ni),
         .ev_i         (ev_i),
         .ctrl_we_i    (bus_wr_i && sel_c),
         .ctrl_wdata_i (bus_wdata_i),
         .hi_rd_i      (bus_rd_i && sel_h),
         .lo_rd_i      (bus_rd_i && sel_l),
         .ctrl_rdata_o (c_rd),
         .hi_rdata_o   (h_rd),
         .lo_rdata_o   (l_rd)
      );

      assign part[i] = ({32{bus_rd_i && sel_c}} & {16'b0, c_rd}) |
                       ({32{bus_rd_i && sel_h}} & h_rd) |
                       ({32{bus_rd_i && sel_l}} & l_rd);

      assert_hi_upper_zero_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bus_rd_i && sel_h) |-> ((h_rd >> HI_W) == 32'd0));
      assert_clr_reads_zero_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bus_rd_i && sel_c) |-> !bus_rdata_o[B_CLR]);
   end

   always_comb begin
      bus_rdata_o = '0;
      for (int i = 0; i < NUM_CTR; i++) bus_rdata_o = bus_rdata_o | part[i];
   end

   assert_idle_rdata_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bus_rd_i |-> (bus_rdata_o == 32'd0));
endmodule

// File: tb/sim_pmu_dual_counter.sv
`timescale 1ns/1ps
module sim_pmu_dual_counter;
   localparam int CW = 12;
   localparam int LW = 8;
   localparam int NC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] ev = '0;
   logic        b_sp = 1'b0, b_rd = 1'b0, b_wr = 1'b0;
   logic [7:0]  b_addr = '0;
   logic [15:0] b_wd = '0;
   logic [31:0] b_rdata;

   int    n_run = 0, n_fail = 0;
   bit    done = 1'b0;
   string cur_tag = "R10";

   int unsigned m_cnt [NC];
   int unsigned m_sh  [NC];
   bit          m_pend[NC];
   logic [15:0] m_ctrl[NC];

   always #4 clk = ~clk;

   pmu_dual_counter #(.CNT_W(CW), .LO_W(LW), .NUM_CTR(NC), .AW(8), .SHADOW(1'b1)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .bus_space_i(b_sp), .bus_addr_i(b_addr),
      .bus_wr_i(b_wr), .bus_rd_i(b_rd), .bus_wdata_i(b_wd), .bus_rdata_o(b_rdata));

   function automatic bit assigned(input int c);
      return (c >= 1 && c <= 11) || (c >= 13 && c <= 26) ||
             (c >= 33 && c <= 37) || (c >= 39 && c <= 41);
   endfunction

   initial for (int i = 0; i < NC; i++) begin
      m_cnt[i] = 0; m_sh[i] = 0; m_pend[i] = 0; m_ctrl[i] = '0;
   end

   // behavioural reference, one update per edge
   always @(posedge clk) begin
      for (int i = 0; i < NC; i++) begin
         if (!rst_n) begin
            m_cnt[i] = 0; m_sh[i] = 0; m_pend[i] = 0; m_ctrl[i] = '0;
         end else begin
            int  code;
            bit  fire, clr, hird, lord;
            code = int'(m_ctrl[i][5:0]);
            fire = m_ctrl[i][15] && m_ctrl[i][14] && assigned(code) && ev[code];
            clr  = b_wr && !b_sp && b_addr == 8'(4*i) && b_wd[13];
            hird = b_rd && b_sp && b_addr == 8'(8*i);
            lord = b_rd && b_sp && b_addr == 8'(8*i+4);
            if (clr) m_pend[i] = 0;
            else if (hird) begin m_sh[i] = m_cnt[i] % (1 << LW); m_pend[i] = 1; end
            else if (lord) m_pend[i] = 0;
            if (clr) m_cnt[i] = 0;
            else if (fire) m_cnt[i] = (m_cnt[i] + 1) % (1 << CW);
            if (b_wr && !b_sp && b_addr == 8'(4*i)) m_ctrl[i] = b_wd & 16'hC13F;
         end
      end
   end

   function automatic logic [31:0] exp_rd();
      if (!b_rd) return 32'd0;
      for (int i = 0; i < NC; i++) begin
         if (!b_sp && b_addr == 8'(4*i)) return {16'd0, m_ctrl[i]};
         if (b_sp && b_addr == 8'(8*i)) return 32'(m_cnt[i] >> LW);
         if (b_sp && b_addr == 8'(8*i+4))
            return m_pend[i] ? 32'(m_sh[i]) : 32'(m_cnt[i] % (1 << LW));
      end
      return 32'd0;
   endfunction

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      #2;
      if (!done) begin
         logic [31:0] e;
         e = exp_rd();
         n_run++;
         if (b_rdata !== e) begin
            n_fail++;
            $display("FAIL %s rdata=%h expected=%h (sp=%0d addr=%h)", cur_tag, b_rdata, e, b_sp, b_addr);
         end
      end
   end

   task automatic step(input bit sp, input logic [7:0] a, input bit r, input bit w,
                       input logic [15:0] d, input string tag);
      @(negedge clk);
      b_sp = sp; b_addr = a; b_rd = r; b_wr = w; b_wd = d; cur_tag = tag;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired tag=%s actual=hung expected=finished", cur_tag);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: reset state of every register, plus unmapped address
      step(0, 8'h00, 1, 0, 0, "R10");
      step(0, 8'h04, 1, 0, 0, "R10");
      for (int a = 0; a < 16; a += 4) step(1, 8'(a), 1, 0, 0, "R10");
      step(1, 8'h20, 1, 0, 0, "R10");
      step(0, 8'h02, 1, 0, 0, "R10");
      // R1/R2: two counters on different codes, different pulse trains
      step(0, 8'h00, 0, 1, 16'hC001, "R1");
      step(0, 8'h04, 0, 1, 16'hC010, "R1");
      for (int k = 0; k < 60; k++) begin
         ev = '0; ev[1] = (k % 3 == 0); ev[16] = ((k * 7) % 5 < 2); ev[2] = 1'b1;
         step(1, (k % 2) ? 8'h04 : 8'h0C, 1, 0, 0, "R1");
      end
      // R2: start only, then enable only, hold the counts
      step(0, 8'h00, 0, 1, 16'h4001, "R2");
      step(0, 8'h04, 0, 1, 16'h8010, "R2");
      for (int k = 0; k < 20; k++) begin
         ev = '1;
         step(1, 8'(4 + 8 * (k % 2)), 1, 0, 0, "R2");
      end
      // R5: readback of held bits only
      step(0, 8'h00, 0, 1, 16'hFFFF, "R5");
      step(0, 8'h00, 1, 0, 0, "R5");
      step(0, 8'h04, 0, 1, 16'h013F, "R5");
      step(0, 8'h04, 1, 0, 0, "R5");
      // R3: unassigned codes with all events high
      foreach (m_cnt[i]) begin end
      for (int c = 0; c < 64; c++) begin
         if (!assigned(c)) begin
            ev = '1;
            step(0, 8'h00, 0, 1, 16'hC000 | 16'(c), "R3");
            step(1, 8'h04, 1, 0, 0, "R3");
            step(1, 8'h04, 1, 0, 0, "R3");
         end
      end
      // R4: clear while the event fires, then readback
      step(0, 8'h00, 0, 1, 16'hC013, "R4");
      for (int k = 0; k < 10; k++) step(1, 8'h04, 1, 0, 0, "R4");
      step(0, 8'h00, 0, 1, 16'hE013, "R4");
      step(1, 8'h04, 1, 0, 0, "R4");
      step(0, 8'h00, 1, 0, 0, "R4");
      for (int k = 0; k < 5; k++) step(1, 8'h04, 1, 0, 0, "R4");
      // R8: writes into the counter window
      step(1, 8'h04, 0, 1, 16'hFFFF, "R8");
      step(1, 8'h00, 0, 1, 16'h1234, "R8");
      step(1, 8'h04, 1, 0, 0, "R8");
      step(1, 8'h00, 1, 0, 0, "R8");
      // R7: capture, delay, consume, clear drops capture
      step(1, 8'h00, 1, 0, 0, "R7");
      for (int k = 0; k < 4; k++) step(0, 8'h00, 0, 0, 0, "R7");
      step(1, 8'h04, 1, 0, 0, "R7");
      step(1, 8'h04, 1, 0, 0, "R7");
      step(1, 8'h00, 1, 0, 0, "R7");
      step(0, 8'h00, 0, 1, 16'hE023, "R7");
      step(1, 8'h04, 1, 0, 0, "R7");
      // R6/R9: elapsed-cycle code on counter 1 until it rolls over
      ev = '0; ev[35] = 1'b1;
      step(0, 8'h04, 0, 1, 16'hE023, "R9");
      for (int k = 0; k < 4200; k++)
         step(1, (k % 2) ? 8'h0C : 8'h08, 1, 0, 0, (k % 2) ? "R9" : "R6");
      step(0, 8'h00, 0, 0, 0, "R10");
      step(0, 8'h00, 0, 0, 0, "R10");
      finish_run();
   end
endmodule